// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns 32-bit stereo frames into a three-wire serial audio stream: one data line and two clock lines, a bit clock and a word-select clock. Frames enter through a small first-in first-out buffer with a valid/ready push port. Each frame carries two 16-bit samples. The upper sample goes out first, and each sample is sent most significant bit first. The bit clock is derived from the system clock at a fixed ratio: three system clocks low, then three high, for every bit. This ratio holds across frame boundaries, because the next frame is fetched during the high half of the previous frame's last bit.

A static mode input selects where word-select switches. In standard mode it switches one bit ahead of the most significant bit of a sample. In left-justified mode it switches together with that bit. A second static input exchanges the two clock pins, so that board wiring in either order can be served. If the buffer is empty when a frame is due, the last frame that was sent goes out again. The stored copy resets to zero, so an empty buffer after reset produces silence. An enable input starts transmission only at a frame boundary. When enable is dropped, the current frame finishes and the outputs return to their idle levels.

Top module: `i2s_stereo_tx`

## Requirements
- R1: While idle (after reset, or with enable low after a frame has ended), the bit clock is 1 and the data line is 0. Word-select is 1 in standard mode (`lj_mode_i`=0) and 0 in left-justified mode (`lj_mode_i`=1).
- R2: Every transmitted bit occupies exactly 3 system clocks with the bit clock at 0, followed by 3 with it at 1. Data changes only on the cycle the bit clock falls.
- R3: After enable rises while idle, the bit clock stays at 1 for one recognition cycle plus 3 preamble cycles, then falls for the first bit. Dropping enable in the middle of a frame lets that frame finish all 32 bits, after which the block idles.
- R4: Frame bit 31 goes out first and bit 0 last (upper sample first, MSB first), 32 bits per frame.
- R5: Consecutive frames follow with no gap. The high phase of the last bit of a frame lasts exactly 3 clocks, like every other high phase.
- R6: If the buffer is empty at a frame fetch, the previously sent frame is sent again. After reset, this stored frame is all zeros.
- R7: In standard mode, word-select is 1 for bits 0 to 14 of the frame (counted in send order), 0 for bits 15 to 30, and 1 for bit 31. It changes only when the bit clock falls.
- R8: In left-justified mode, word-select is 1 for send-order bits 0 to 15 and 0 for bits 16 to 31.
- R9: With `swap_pins_i`=0, `pin_a_o` carries the bit clock and `pin_b_o` carries word-select. With `swap_pins_i`=1, the assignment is exchanged and both waveforms are unchanged.
- R10: The buffer holds 4 frames. `push_ready_o` is 1 exactly when it is not full. `fifo_full_o` and `fifo_empty_o` report its state. A push while full is dropped and never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Start or continue transmission at frame boundaries |
| lj_mode_i | input | 1 | 0: standard alignment, 1: left-justified (static) |
| swap_pins_i | input | 1 | Exchange bit clock and word-select pins (static) |
| push_valid_i | input | 1 | Frame offered on push_data_i |
| push_data_i | input | 32 | Stereo frame, upper half sent first |
| push_ready_o | output | 1 | Buffer can accept a frame |
| fifo_full_o | output | 1 | Buffer is full |
| fifo_empty_o | output | 1 | Buffer is empty |
| sdata_o | output | 1 | Serial data |
| pin_a_o | output | 1 | Bit clock (or word-select when swapped) |
| pin_b_o | output | 1 | Word-select (or bit clock when swapped) |

## Verification
The assertions check on every cycle the properties that depend only on the bit clock. They cover the 3-cycle low and high phase lengths, including the high phase at frame boundaries. They also check that data holds between falling edges, that word-select moves only on a falling edge, that the bit clock stays high while idle, and that the full flag rises only after an accepted push. Other behaviour is shown only by the bench's scenarios, which decode the pins back into frames: the frame content and bit order, the replay of the last frame on an empty buffer, the zero frame after reset, the dropped push, the preamble length, the exact word-select pattern in each mode, and the pin exchange.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_PRE  = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("i2s_tx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [AW:0]      cnt_q;

   assign full    = (cnt_q == CNT_MAX);
   assign empty   = (cnt_q == '0);
   assign rd_data = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_en) wp_q <= wp_q + 1'b1;
         if (rd_en) rp_q <= rp_q + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/i2s_tx_seq.sv
module i2s_tx_seq
   import i2s_tx_pkg::*;
#(
   parameter int FRAME_W    = 32,
   parameter int PHASE_CLKS = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       enable,
   input  logic                       fifo_empty,
   input  logic [FRAME_W-1:0]         fifo_data,
   output logic                       fifo_pop,
   output logic                       running,
   output logic [$clog2(FRAME_W)-1:0] bit_idx,
   output logic                       bclk,
   output logic                       sdata
);
   localparam int BW = $clog2(FRAME_W);
   localparam int PW = $clog2(2 * PHASE_CLKS);
   localparam logic [PW-1:0] PH_PRE_END = PW'(PHASE_CLKS - 1);
   localparam logic [PW-1:0] PH_HIGH    = PW'(PHASE_CLKS);
   localparam logic [PW-1:0] PH_LAST    = PW'(2 * PHASE_CLKS - 1);
   localparam logic [BW-1:0] BIT_LAST   = BW'(FRAME_W - 1);

   seq_state_t         state_q;
   logic [PW-1:0]      ph_q;
   logic [BW-1:0]      bidx_q;
   logic [FRAME_W-1:0] shreg_q, saved_q, next_frame;
   logic               fetch, end_of_bit, end_of_frame;

   assign end_of_bit   = (state_q == SEQ_RUN) && (ph_q == PH_LAST);
   assign end_of_frame = end_of_bit && (bidx_q == BIT_LAST);
   assign fetch        = ((state_q == SEQ_PRE) && (ph_q == PH_PRE_END)) ||
                         (end_of_frame && enable);
   assign next_frame   = fifo_empty ? saved_q : fifo_data;
   assign fifo_pop     = fetch && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         ph_q    <= '0;
         bidx_q  <= '0;
         shreg_q <= '0;
         saved_q <= '0;
      end else begin
         if (fetch) begin
            shreg_q <= next_frame;
            saved_q <= next_frame;
         end else if (end_of_bit) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
         end
         unique case (state_q)
            SEQ_IDLE: begin
               ph_q <= '0;
               if (enable) state_q <= SEQ_PRE;
            end
            SEQ_PRE: begin
               if (ph_q == PH_PRE_END) begin
                  state_q <= SEQ_RUN;
                  ph_q    <= '0;
                  bidx_q  <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            SEQ_RUN: begin
               if (end_of_bit) begin
                  ph_q   <= '0;
                  bidx_q <= bidx_q + 1'b1;
                  if (end_of_frame) begin
                     bidx_q <= '0;
                     if (!enable) state_q <= SEQ_IDLE;
                  end
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign running = (state_q == SEQ_RUN);
   assign bit_idx = bidx_q;
   assign bclk    = !running || (ph_q >= PH_HIGH);
   assign sdata   = running && shreg_q[FRAME_W-1];
endmodule

// File: rtl/i2s_tx_wsgen.sv
module i2s_tx_wsgen #(
   parameter int FRAME_W = 32
) (
   input  logic                       running,
   input  logic                       lj_mode,
   input  logic [$clog2(FRAME_W)-1:0] bit_idx,
   output logic                       ws
);
   localparam int BW = $clog2(FRAME_W);
   localparam logic [BW-1:0] HALF     = BW'(FRAME_W / 2);
   localparam logic [BW-1:0] HALF_M1  = BW'(FRAME_W / 2 - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);

   always_comb begin
      if (!running)
         ws = !lj_mode;
      else if (lj_mode)
         ws = (bit_idx < HALF);
      else
         ws = (bit_idx < HALF_M1) || (bit_idx == BIT_LAST);
   end
endmodule

// File: rtl/i2s_tx_pinmap.sv
module i2s_tx_pinmap (
   input  logic swap,
   input  logic bclk,
   input  logic ws,
   output logic pin_a,
   output logic pin_b
);
   assign pin_a = swap ? ws : bclk;
   assign pin_b = swap ? bclk : ws;
endmodule

// File: rtl/i2s_stereo_tx.sv
module i2s_stereo_tx #(
   parameter int SAMPLE_W   = 16,
   parameter int FIFO_DEPTH = 4,
   parameter int PHASE_CLKS = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable_i,
   input  logic                    lj_mode_i,
   input  logic                    swap_pins_i,
   input  logic                    push_valid_i,
   input  logic [2*SAMPLE_W-1:0]   push_data_i,
   output logic                    push_ready_o,
   output logic                    fifo_full_o,
   output logic                    fifo_empty_o,
   output logic                    sdata_o,
   output logic                    pin_a_o,
   output logic                    pin_b_o
);
   localparam int FRAME_W = 2 * SAMPLE_W;
   localparam int BW      = $clog2(FRAME_W);

   generate
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("i2s_stereo_tx: SAMPLE_W must be at least 2");
      end
      if (PHASE_CLKS < 1) begin : g_bad_phase
         $error("i2s_stereo_tx: PHASE_CLKS must be at least 1");
      end
   endgenerate

   logic               fifo_pop, seq_running, bclk_int, ws_int;
   logic [FRAME_W-1:0] fifo_head;
   logic [BW-1:0]      bit_idx;

   assign push_ready_o = !fifo_full_o;

   i2s_tx_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_valid_i && push_ready_o),
      .wr_data (push_data_i),
      .rd_en   (fifo_pop),
      .rd_data (fifo_head),
      .full    (fifo_full_o),
      .empty   (fifo_empty_o)
   );

   i2s_tx_seq #(.FRAME_W(FRAME_W), .PHASE_CLKS(PHASE_CLKS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable_i),
      .fifo_empty (fifo_empty_o),
      .fifo_data  (fifo_head),
      .fifo_pop   (fifo_pop),
      .running    (seq_running),
      .bit_idx    (bit_idx),
      .bclk       (bclk_int),
      .sdata      (sdata_o)
   );

   i2s_tx_wsgen #(.FRAME_W(FRAME_W)) u_wsgen (
      .running (seq_running),
      .lj_mode (lj_mode_i),
      .bit_idx (bit_idx),
      .ws      (ws_int)
   );

   i2s_tx_pinmap u_pinmap (
      .swap  (swap_pins_i),
      .bclk  (bclk_int),
      .ws    (ws_int),
      .pin_a (pin_a_o),
      .pin_b (pin_b_o)
   );
endmodule

// File: rtl/i2s_stereo_tx_checker.sv
module i2s_stereo_tx_checker #(
   parameter int PHASE_CLKS = 3
) (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic bclk,
   input logic ws,
   input logic sd,
   input logic lj_mode,
   input logic push_valid,
   input logic push_ready,
   input logic full
);
   localparam logic [7:0] PH = 8'(PHASE_CLKS);
   logic [7:0] low_cnt, high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         high_cnt <= '0;
      end else begin
         low_cnt  <= bclk ? 8'd0 : ((low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1);
         high_cnt <= !bclk ? 8'd0 : ((high_cnt == 8'hFF) ? high_cnt : high_cnt + 8'd1);
      end
   end

   assert_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk) |-> (low_cnt == PH));

   assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$fell(bclk)) |-> $stable(sd));

   assert_boundary_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bclk) && $past(run)) |-> (high_cnt == PH));

   assert_ws_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(lj_mode) && !$stable(ws)) |-> $fell(bclk));

   assert_idle_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> bclk);

   assert_full_after_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(push_valid && push_ready));
endmodule

bind i2s_stereo_tx i2s_stereo_tx_checker #(.PHASE_CLKS(PHASE_CLKS)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (seq_running),
   .bclk       (bclk_int),
   .ws         (ws_int),
   .sd         (sdata_o),
   .lj_mode    (lj_mode_i),
   .push_valid (push_valid_i),
   .push_ready (push_ready_o),
   .full       (fifo_full_o)
);

// File: tb/i2s_stereo_tx_bench.sv
module i2s_stereo_tx_bench;
   localparam int PH = 3;
   localparam int FW = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        enable_i = 1'b0, lj_mode_i = 1'b0, swap_pins_i = 1'b0;
   logic        push_valid_i = 1'b0;
   logic [31:0] push_data_i = '0;
   logic        push_ready_o, fifo_full_o, fifo_empty_o, sdata_o, pin_a_o, pin_b_o;

   i2s_stereo_tx u_i2s_stereo_tx (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .lj_mode_i(lj_mode_i),
      .swap_pins_i(swap_pins_i), .push_valid_i(push_valid_i), .push_data_i(push_data_i),
      .push_ready_o(push_ready_o), .fifo_full_o(fifo_full_o), .fifo_empty_o(fifo_empty_o),
      .sdata_o(sdata_o), .pin_a_o(pin_a_o), .pin_b_o(pin_b_o)
   );

   int errors = 0, checks = 0, frames_done = 0, mon_bit = 0;
   bit reported = 0;
   logic [31:0] exp_q [$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic logic bclk_pin();
      return swap_pins_i ? pin_b_o : pin_a_o;
   endfunction
   function automatic logic ws_pin();
      return swap_pins_i ? pin_a_o : pin_b_o;
   endfunction

   // Monitor: decodes the pins into frames and compares with the scoreboard
   initial begin
      int low_len, high_len;
      bit started;
      logic prev_b, b, w, exp_ws;
      logic [31:0] word, e;
      low_len = 0; high_len = 100; started = 0; prev_b = 1'b1; word = '0;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         b = bclk_pin();
         w = ws_pin();
         if (!b) begin
            if (prev_b) begin
               if (started) check(high_len == PH, "R5", "high phase length", high_len, PH);
               started = 1;
               low_len = 0;
            end
            low_len++;
         end else begin
            if (!prev_b) begin
               check(low_len == PH, "R2", "low phase length", low_len, PH);
               word   = {word[30:0], sdata_o};
               exp_ws = lj_mode_i ? (mon_bit < 16) : ((mon_bit < 15) || (mon_bit == 31));
               check(w == exp_ws, lj_mode_i ? "R8" : "R7", "word-select level", w, exp_ws);
               mon_bit++;
               if (mon_bit == FW) begin
                  mon_bit = 0;
                  if (exp_q.size() == 0) begin
                     check(0, "R4", "unexpected frame", word, 0);
                  end else begin
                     e = exp_q.pop_front();
                     check(word == e, "R4", "frame content", word, e);
                  end
                  frames_done++;
               end
               high_len = 0;
            end
            high_len++;
            if (high_len > PH) started = 0;
         end
         prev_b = b;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "watchdog", "run did not finish", 0, 1);
      report();
   end

   task automatic push_frame(input logic [31:0] d, input bit expect_accept);
      bit acc;
      @(negedge clk);
      push_valid_i = 1'b1;
      push_data_i  = d;
      acc = push_ready_o;
      @(negedge clk);
      push_valid_i = 1'b0;
      if (acc) exp_q.push_back(d);
      check(acc == expect_accept, "R10", "push acceptance", acc, expect_accept);
   endtask

   task automatic check_idle(input string req);
      check(bclk_pin() == 1'b1, req, "idle bit clock", bclk_pin(), 1);
      check(ws_pin() == !lj_mode_i, req, "idle word-select", ws_pin(), !lj_mode_i);
      check(sdata_o == 1'b0, req, "idle data", sdata_o, 0);
   endtask

   task automatic run_frames(input int k);
      int base;
      base = frames_done;
      @(negedge clk);
      enable_i = 1'b1;
      for (int i = 1; i <= 4; i++) begin
         @(negedge clk);
         check(bclk_pin() == (i < 4), "R3", "preamble bit clock", bclk_pin(), (i < 4));
      end
      while (!(frames_done == base + k - 1 && mon_bit >= 2)) @(negedge clk);
      enable_i = 1'b0;
      while (frames_done != base + k) @(negedge clk);
      repeat (4 * PH) @(negedge clk);
      check(exp_q.size() == 0, "R3", "frames left unsent", exp_q.size(), 0);
      check(frames_done == base + k, "R3", "frames after enable drop", frames_done - base, k);
      check_idle("R1");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check_idle("R1");
      check(fifo_empty_o == 1'b1, "R10", "empty after reset", fifo_empty_o, 1);
      check(fifo_full_o == 1'b0, "R10", "full after reset", fifo_full_o, 0);
      check(push_ready_o == 1'b1, "R10", "ready after reset", push_ready_o, 1);

      // R6: empty buffer after reset sends a zero frame
      exp_q.push_back(32'h0000_0000);
      run_frames(1);

      // R10 + R6: fill, drop a push while full, then replay the last frame
      push_frame(32'hA5C3_0F96, 1);
      push_frame(32'h8001_7FFE, 1);
      push_frame(32'hFFFF_0000, 1);
      push_frame(32'h1234_5678, 1);
      check(fifo_full_o == 1'b1, "R10", "full after four pushes", fifo_full_o, 1);
      check(push_ready_o == 1'b0, "R10", "ready while full", push_ready_o, 0);
      push_frame(32'hDEAD_BEEF, 0);
      exp_q.push_back(32'h1234_5678);
      run_frames(5);
      check(fifo_empty_o == 1'b1, "R10", "empty after drain", fifo_empty_o, 1);

      // R9 + R8: left-justified with swapped pins
      @(negedge clk);
      lj_mode_i = 1'b1;
      swap_pins_i = 1'b1;
      repeat (2) @(negedge clk);
      check(pin_a_o == 1'b0, "R9", "pin A carries word-select", pin_a_o, 0);
      check(pin_b_o == 1'b1, "R9", "pin B carries bit clock", pin_b_o, 1);
      push_frame(32'h0F0F_F0F0, 1);
      push_frame(32'h7FFF_8000, 1);
      push_frame(32'h0001_0001, 1);
      run_frames(3);

      // R8 + R4: left-justified, normal pins, MSB-first patterns
      @(negedge clk);
      swap_pins_i = 1'b0;
      repeat (2) @(negedge clk);
      check(pin_a_o == 1'b1, "R9", "pin A carries bit clock", pin_a_o, 1);
      push_frame(32'h8000_0001, 1);
      push_frame(32'h0001_8000, 1);
      run_frames(2);

      // R7: standard mode again, replay of the last frame
      @(negedge clk);
      lj_mode_i = 1'b0;
      repeat (2) @(negedge clk);
      check_idle("R1");
      exp_q.push_back(32'h0001_8000);
      run_frames(1);

      report();
   end
endmodule